// File: doc/BRIEF.md
# Overlapped Register Window File

This block is the register file of a processor that gives every procedure a fresh set of registers on a call without copying anything. Seventy-four physical storage words sit behind a 32-entry logical view. The view slides by sixteen physical entries per window, and there are four windows arranged in a ring. The lowest ten logical registers are the same physical words in every window. The upper twenty-two logical registers are split three ways. The first six are the incoming set. The next ten are private to the procedure. The last six are the outgoing set, and these are physically the same words as the incoming set of the next window.

A caller places arguments in its outgoing registers and then raises the call input. From the next cycle the callee finds those values in its incoming registers, and results travel back by the same shared words. Returning moves the view back by one window. The window index wraps in both directions, so the outgoing set of the last window is the incoming set of the first.

Saving windows to memory is left to other logic. The block keeps a count of nested calls and raises a flag when a call would reuse a window that is still live, or when a return has no matching call. The block has two combinational read ports and one write port that takes effect at the clock edge. All three ports use logical register numbers.

Top module: `regwin_file`

## Requirements
- R1: After reset the window index and the nesting depth are 0, both flags are low, and every register reads as 0.
- R2: Logical registers 0 to 9 address physical 0 to 9 in every window, so a value written there is visible unchanged after any number of calls or returns.
- R3: In window w, logical register n from 10 to 31 addresses physical n + 16·w, minus 64 when that sum exceeds 73. A callee's logical 10 to 15 are therefore the caller's logical 26 to 31, and each window's logical 16 to 25 are private to that window.
- R4: The outgoing registers (logical 26 to 31) of window 3 are the same storage as the incoming registers (logical 10 to 15) of window 0.
- R5: A call alone advances the window index by one, modulo 4, at the next clock edge. A return alone moves it back by one, modulo 4.
- R6: When call and return are asserted in the same cycle, the window index and the depth do not change and neither flag is raised.
- R7: The nesting depth rises by one on a call taken below depth 3 and falls by one on a return taken above depth 0.
- R8: The overflow flag is high during the cycle in which a call is requested at depth 3. The window index still advances and the depth stays at 3.
- R9: The underflow flag is high during the cycle in which a return is requested at depth 0. The window index still moves back and the depth stays at 0.
- R10: Both read ports are combinational and independent of each other. A write takes effect at the clock edge, so a read of the register being written in that cycle returns the old value.
- R11: Reads and writes in a cycle are mapped with the window index held before that cycle's edge, even when a call or return is requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| callReq | input | 1 | Enter the next window |
| retReq | input | 1 | Go back to the previous window |
| rdAddrA | input | 5 | Logical register number, read port A |
| rdDataA | output | 32 | Read data, port A |
| rdAddrB | input | 5 | Logical register number, read port B |
| rdDataB | output | 32 | Read data, port B |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Logical register number for the write |
| wrData | input | 32 | Write data |
| curWindow | output | 2 | Current window index |
| nestDepth | output | 2 | Count of live nested calls |
| winOverflow | output | 1 | A call was requested with no free window |
| winUnderflow | output | 1 | A return was requested at depth 0 |

## Verification
The translation is exercised by several kinds of access. Writing globals in one window and reading them in others separates the fixed mapping from the sliding one. Filling the outgoing set before a call and reading the incoming set afterwards checks the overlap, and writing back after the call checks the result path. Running through four calls exposes an off-by-one in the 64-entry wrap, and locals reading zero in a fresh window show that the windows stay separate. Calls at full depth, a return at depth zero, call with return in the same cycle, and a write issued in the same cycle as a call each check a different control rule. A same-cycle read and write of one register shows whether the read path bypasses the write.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  // Window geometry
  localparam int RW_GLOBALS = 10;
  localparam int RW_LOCALS  = 10;
  localparam int RW_SHARED  = 6;
  localparam int RW_WINDOWS = 4;

  // Derived sizes
  localparam int RW_STRIDE  = RW_LOCALS + RW_SHARED;
  localparam int RW_PHYS    = RW_STRIDE * RW_WINDOWS + RW_GLOBALS;
  localparam int RW_LOGICAL = RW_GLOBALS + RW_LOCALS + 2 * RW_SHARED;
  localparam int RW_LOG_W   = $clog2(RW_LOGICAL);
  localparam int RW_PHYS_W  = $clog2(RW_PHYS);
  localparam int RW_CWP_W   = $clog2(RW_WINDOWS);

  // Strobes from control to datapath
  typedef struct packed {
    logic [RW_CWP_W-1:0] cwp;
    logic                wrStrobe;
  } winCtl_t;

  // Logical-to-physical translation for a given window
  function automatic logic [RW_PHYS_W-1:0] toPhys(input logic [RW_CWP_W-1:0] win,
                                                  input logic [RW_LOG_W-1:0] lreg);
    int p;
    if (int'(lreg) < RW_GLOBALS) begin
      p = int'(lreg);
    end else begin
      p = int'(lreg) + RW_STRIDE * int'(win);
      if (p >= RW_PHYS) p = p - RW_STRIDE * RW_WINDOWS;
    end
    return RW_PHYS_W'(p);
  endfunction

endpackage

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                callReq,
  input  logic                retReq,
  input  logic                wrEn,
  output winCtl_t             ctl,
  output logic [RW_CWP_W-1:0] depth,
  output logic                overflow,
  output logic                underflow
);

  localparam logic [RW_CWP_W-1:0] LAST_WIN  = RW_CWP_W'(RW_WINDOWS - 1);
  localparam logic [RW_CWP_W-1:0] MAX_DEPTH = RW_CWP_W'(RW_WINDOWS - 1);

  logic [RW_CWP_W-1:0] cwpQ, cwpNext;
  logic [RW_CWP_W-1:0] depthQ, depthNext;
  logic doCall, doRet;

  assign doCall = callReq & ~retReq;
  assign doRet  = retReq & ~callReq;

  assign overflow  = doCall && (depthQ == MAX_DEPTH);
  assign underflow = doRet && (depthQ == '0);

  always_comb begin
    cwpNext   = cwpQ;
    depthNext = depthQ;
    if (doCall) begin
      cwpNext = (cwpQ == LAST_WIN) ? '0 : cwpQ + 1'b1;
      if (depthQ != MAX_DEPTH) depthNext = depthQ + 1'b1;
    end else if (doRet) begin
      cwpNext = (cwpQ == '0) ? LAST_WIN : cwpQ - 1'b1;
      if (depthQ != '0) depthNext = depthQ - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cwpQ   <= '0;
      depthQ <= '0;
    end else begin
      cwpQ   <= cwpNext;
      depthQ <= depthNext;
    end
  end

  assign ctl.cwp      = cwpQ;
  assign ctl.wrStrobe = wrEn;
  assign depth        = depthQ;

  AST_CALL_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (callReq && !retReq) |=> (int'(cwpQ) == (int'($past(cwpQ)) + 1) % RW_WINDOWS)); // R5
  AST_RET_BACK: assert property (@(posedge clk) disable iff (!rstN)
    (retReq && !callReq) |=> (int'(cwpQ) == (int'($past(cwpQ)) + RW_WINDOWS - 1) % RW_WINDOWS)); // R5
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (callReq && retReq) |=> ($stable(cwpQ) && $stable(depthQ))); // R6
  AST_NO_OVERFLOW_SLIP: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> (depthQ == MAX_DEPTH)); // R8
  AST_NO_UNDERFLOW_SLIP: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> (depthQ == '0)); // R9
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $countones({overflow, underflow}) <= 1); // R8
  AST_DEPTH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (callReq && !retReq && depthQ != MAX_DEPTH) |=> (depthQ == $past(depthQ) + 1'b1)); // R7

endmodule

// File: rtl/regwin_datapath.sv
module regwin_datapath
  import regwin_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  winCtl_t             ctl,
  input  logic [RW_LOG_W-1:0] rdAddrA,
  input  logic [RW_LOG_W-1:0] rdAddrB,
  input  logic [RW_LOG_W-1:0] wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdDataA,
  output logic [DATA_W-1:0]   rdDataB
);

  logic [DATA_W-1:0]    regs [RW_PHYS];
  logic [RW_PHYS_W-1:0] physA, physB, physW;

  // All ports are translated with the window index held this cycle
  assign physA = toPhys(ctl.cwp, rdAddrA);
  assign physB = toPhys(ctl.cwp, rdAddrB);
  assign physW = toPhys(ctl.cwp, wrAddr);

  // One storage word per physical register
  for (genvar i = 0; i < RW_PHYS; i++) begin : gWord
    logic hit;
    assign hit = ctl.wrStrobe && (physW == RW_PHYS_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN)    regs[i] <= '0;
      else if (hit) regs[i] <= wrData;
    end
  end

  // Combinational reads, no bypass from the write port
  assign rdDataA = (int'(physA) < RW_PHYS) ? regs[physA] : '0;
  assign rdDataB = (int'(physB) < RW_PHYS) ? regs[physB] : '0;

  always_comb begin
    AST_PHYS_RANGE_A: assert (int'(physA) < RW_PHYS); // R3
    AST_PHYS_RANGE_B: assert (int'(physB) < RW_PHYS); // R3
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrStrobe |=> (regs[$past(physW)] == $past(wrData))); // R10
  AST_GLOBAL_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (int'(rdAddrA) < RW_GLOBALS) |-> (physA == RW_PHYS_W'(rdAddrA))); // R2

endmodule

// File: rtl/regwin_file.sv
module regwin_file
  import regwin_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                callReq,
  input  logic                retReq,
  input  logic [RW_LOG_W-1:0] rdAddrA,
  output logic [DATA_W-1:0]   rdDataA,
  input  logic [RW_LOG_W-1:0] rdAddrB,
  output logic [DATA_W-1:0]   rdDataB,
  input  logic                wrEn,
  input  logic [RW_LOG_W-1:0] wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [RW_CWP_W-1:0] curWindow,
  output logic [RW_CWP_W-1:0] nestDepth,
  output logic                winOverflow,
  output logic                winUnderflow
);

  winCtl_t ctl;

  regwin_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .callReq   (callReq),
    .retReq    (retReq),
    .wrEn      (wrEn),
    .ctl       (ctl),
    .depth     (nestDepth),
    .overflow  (winOverflow),
    .underflow (winUnderflow)
  );

  regwin_datapath #(.DATA_W(DATA_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .rdAddrA (rdAddrA),
    .rdAddrB (rdAddrB),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdDataA (rdDataA),
    .rdDataB (rdDataB)
  );

  assign curWindow = ctl.cwp;

endmodule

// File: tb/regwin_file_test.sv
`timescale 1ns/1ps
module regwin_file_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        callReq = 1'b0, retReq = 1'b0, wrEn = 1'b0;
  logic [4:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdDataA, rdDataB;
  logic [1:0]  curWindow, nestDepth;
  logic        winOverflow, winUnderflow;

  regwin_file uut (
    .clk(clk), .rstN(rstN), .callReq(callReq), .retReq(retReq),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .curWindow(curWindow), .nestDepth(nestDepth),
    .winOverflow(winOverflow), .winUnderflow(winUnderflow)
  );

  always #2 clk = ~clk;

  // Scoreboard item: which output, expected value, requirement tag
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state, built from the requirements
  logic [31:0] model [74];
  int cwpM = 0;
  int depthM = 0;

  function automatic int mapP(int w, int n);
    int p;
    if (n < 10) return n;
    p = n + 16 * w;
    if (p > 73) p = p - 64;
    return p;
  endfunction

  function automatic logic [31:0] actualOf(int kind);
    case (kind)
      0: return rdDataA;
      1: return rdDataB;
      2: return 32'(curWindow);
      3: return 32'(nestDepth);
      4: return 32'(winOverflow);
      default: return 32'(winUnderflow);
    endcase
  endfunction

  // Monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = actualOf(it.kind);
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic doWrite(int addr, logic [31:0] data);
    wrEn = 1'b1; wrAddr = 5'(addr); wrData = data;
    tick();
    model[mapP(cwpM, addr)] = data;
    wrEn = 1'b0;
  endtask

  task automatic chkRead(int addrA, int addrB, string tag);
    rdAddrA = 5'(addrA); rdAddrB = 5'(addrB);
    push(0, model[mapP(cwpM, addrA)], tag);
    push(1, model[mapP(cwpM, addrB)], tag);
    tick();
  endtask

  task automatic chkState(string tag);
    push(2, 32'(cwpM), tag);
    push(3, 32'(depthM), tag);
    tick();
  endtask

  task automatic doCall(string tag);
    callReq = 1'b1;
    push(4, (depthM == 3) ? 32'd1 : 32'd0, tag);
    push(5, 32'd0, tag);
    tick();
    callReq = 1'b0;
    cwpM = (cwpM + 1) % 4;
    if (depthM < 3) depthM++;
  endtask

  task automatic doRet(string tag);
    retReq = 1'b1;
    push(4, 32'd0, tag);
    push(5, (depthM == 0) ? 32'd1 : 32'd0, tag);
    tick();
    retReq = 1'b0;
    cwpM = (cwpM + 3) % 4;
    if (depthM > 0) depthM--;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 74; i++) model[i] = '0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1: reset state
    push(4, 32'd0, "R1"); push(5, 32'd0, "R1");
    chkState("R1");
    chkRead(3, 31, "R1");
    chkRead(17, 10, "R1");

    // R2: globals in window 0
    for (int g = 0; g < 10; g++) doWrite(g, 32'hA000_0000 + 32'(g));
    chkRead(0, 9, "R2");

    // Fill window 0 upper registers
    for (int n = 10; n < 32; n++) doWrite(n, 32'h0100_0000 + 32'(n));
    chkRead(16, 25, "R3");

    // R10: same-cycle write and read sees old value, then new
    wrEn = 1'b1; wrAddr = 5'd20; wrData = 32'hDEAD_BEEF;
    rdAddrA = 5'd20; rdAddrB = 5'd21;
    push(0, model[mapP(cwpM, 20)], "R10");
    push(1, model[mapP(cwpM, 21)], "R10");
    tick();
    model[mapP(cwpM, 20)] = 32'hDEAD_BEEF;
    wrEn = 1'b0;
    chkRead(20, 4, "R10");

    // R5/R7: call into window 1
    doCall("R8");
    chkState("R5");
    chkState("R7");
    // R3: callee incoming equals caller outgoing; fresh locals are zero
    push(0, 32'h0100_0000 + 32'd26, "R3"); push(1, 32'h0100_0000 + 32'd31, "R3");
    rdAddrA = 5'd10; rdAddrB = 5'd15; tick();
    push(0, 32'd0, "R3"); push(1, 32'd0, "R3");
    rdAddrA = 5'd16; rdAddrB = 5'd25; tick();
    // R2: globals unchanged after call
    push(0, 32'hA000_0003, "R2"); push(1, 32'hA000_0009, "R2");
    rdAddrA = 5'd3; rdAddrB = 5'd9; tick();

    // Result path: callee writes incoming register, caller reads it back
    doWrite(12, 32'h5555_0012);
    doRet("R9");
    chkState("R5");
    push(0, 32'h5555_0012, "R3"); push(1, 32'h0100_0000 + 32'd27, "R3");
    rdAddrA = 5'd28; rdAddrB = 5'd27; tick();

    // R6: call and return together change nothing
    callReq = 1'b1; retReq = 1'b1;
    push(4, 32'd0, "R6"); push(5, 32'd0, "R6");
    tick();
    callReq = 1'b0; retReq = 1'b0;
    chkState("R6");

    // R11: write issued with a call lands in the old window
    wrEn = 1'b1; wrAddr = 5'd30; wrData = 32'h1111_2222; callReq = 1'b1;
    push(4, 32'd0, "R11");
    tick();
    model[mapP(cwpM, 30)] = 32'h1111_2222;
    wrEn = 1'b0; callReq = 1'b0;
    cwpM = 1; depthM = 1;
    push(0, 32'h1111_2222, "R11"); push(1, 32'd0, "R11");
    rdAddrA = 5'd14; rdAddrB = 5'd20; tick();

    // Into windows 2 and 3
    doCall("R8");
    doCall("R8");
    chkState("R7");
    // R4: window 3 outgoing aliases window 0 incoming
    push(0, 32'h0100_0000 + 32'd10, "R4"); push(1, 32'h0100_0000 + 32'd15, "R4");
    rdAddrA = 5'd26; rdAddrB = 5'd31; tick();
    doWrite(29, 32'h7777_0029);

    // R8: call at depth 3 flags, wraps window, holds depth
    doCall("R8");
    chkState("R8");
    push(0, 32'h7777_0029, "R4"); push(1, 32'hA000_0000, "R2");
    rdAddrA = 5'd13; rdAddrB = 5'd0; tick();

    // Unwind and R9: return at depth 0 flags, moves back, holds depth
    doRet("R9"); doRet("R9"); doRet("R9");
    chkState("R7");
    doRet("R9");
    chkState("R9");
    chkRead(26, 11, "R3");
    doRet("R9");
    chkState("R5");
    chkRead(31, 10, "R3");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule